// File: doc/BRIEF.md
# UART Receiver Mute and Wakeup Unit

This unit sits between a serial receiver's deserialiser and whatever consumes its words on a bus shared by several nodes. Software can put the receiver into a mute state. While muted, the unit hides every received word and its status flags, so the local node ignores traffic meant for other nodes. The unit leaves mute when a wakeup condition occurs.

A select input chooses one of two wakeup methods. In idle mode, the unit wakes when the deserialiser reports an idle line. In address mode, any received word with its most significant bit set is an address word and never data. The low bits of an address word are compared with a programmable node identifier. A match wakes the unit. A mismatch mutes it again, even when it was awake.

The unit works only on whole words: one word with a valid strobe, its status flags and a separate idle-line indication. The mute state also serves as the readback value of the mute request bit. All outputs are registered, and each change appears one clock after the input that causes it.

Top module: `uart_mute_wakeup`

## Requirements
- R1: After reset, `muted`, `rx_valid_o` and `rx_flags_o` are all 0.
- R2: A cycle with `mute_set` high makes `muted` 1 on the next cycle. This takes priority over any wakeup event in the same cycle.
- R3: A word received while `muted` is 1 is not delivered: `rx_valid_o` stays 0 on the next cycle, and its flags are not raised.
- R4: When `wake_sel` is 1 (address mode), a valid word with its MSB (bit DATA_W-1) set is an address word. It is never delivered, whatever the mute state.
- R5: In address mode, an address word whose bits [ID_W-1:0] equal `node_id` clears `muted` on the next cycle, unless R2 applies. Later data words are delivered.
- R6: In address mode, an address word whose bits [ID_W-1:0] differ from `node_id` sets `muted` on the next cycle, even when the unit was awake.
- R7: When `wake_sel` is 0 (idle mode), `idle_det` high while muted clears `muted` on the next cycle, unless R2 applies. A word arriving in that same cycle is still suppressed. In this mode, words with the MSB set are ordinary data.
- R8: `idle_det` has no effect on `muted` in address mode. In idle mode it has no effect while the unit is awake.
- R9: A data word received while awake appears one cycle later, with `rx_valid_o` = 1, `rx_data_o` equal to the word and `rx_flags_o` equal to its flags.
- R10: `rx_flags_o` is all zero in every cycle where `rx_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mute_set | input | 1 | One-cycle request to enter mute |
| wake_sel | input | 1 | Wakeup method: 1 = address match, 0 = idle line |
| node_id | input | ID_W | Identifier compared with an address word's low bits |
| rx_word | input | DATA_W | Word from the deserialiser |
| rx_valid | input | 1 | Strobe marking `rx_word` valid |
| rx_flags | input | FLAG_W | Status flags that come with `rx_word` |
| idle_det | input | 1 | Idle line detected |
| muted | output | 1 | Mute state, also the mute request bit readback |
| rx_valid_o | output | 1 | Gated word-valid strobe |
| rx_data_o | output | DATA_W | Delivered word |
| rx_flags_o | output | FLAG_W | Delivered flags, zero when nothing is delivered |

## Verification
The hardest situation to reach from the ports is one where several events meet in the same cycle. Examples are an address word or an idle pulse arriving together with a word or a mute request, and a mismatched address that reaches the unit while it is awake. Each trial first sets up a known state: it pulses `mute_set` and, where an awake start is wanted, wakes the unit with the mode's own wakeup event. It then applies one test cycle. The sweep covers both modes, every identifier, both start states, both MSB values, every low-nibble value and both idle values. A directed sequence covers a mute request that coincides with a wakeup.

// File: rtl/mute_wake_pkg.sv
package mute_wake_pkg;

  typedef enum logic {
    WAKE_ON_IDLE = 1'b0,
    WAKE_ON_ADDR = 1'b1
  } wake_mode_e;

  typedef struct packed {
    logic is_addr;
    logic hit;
    logic miss;
  } addr_evt_t;

  // Next mute state: a mute request wins; then address events; then idle wake.
  function automatic logic mute_next(
    input logic cur,
    input logic set_req,
    input logic hit,
    input logic miss,
    input logic idle_wake
  );
    logic n;
    n = cur;
    if (set_req)        n = 1'b1;
    else if (miss)      n = 1'b1;
    else if (hit)       n = 1'b0;
    else if (idle_wake) n = 1'b0;
    return n;
  endfunction

  // A word passes the gate only when awake and not an address word.
  function automatic logic word_passes(
    input logic valid,
    input logic is_addr,
    input logic cur_muted
  );
    return valid && !is_addr && !cur_muted;
  endfunction

endpackage

// File: rtl/mw_addr_detect.sv
module mw_addr_detect
  import mute_wake_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ID_W   = 4
) (
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              wake_sel,
  input  logic [ID_W-1:0]   node_id,
  output addr_evt_t         evt
);
  localparam int MSB = DATA_W - 1;

  logic [ID_W-1:0] bit_eq;
  logic            id_equal;
  logic            addr_word;

  generate
    for (genvar i = 0; i < ID_W; i++) begin : g_cmp
      assign bit_eq[i] = (rx_word[i] == node_id[i]);
    end
  endgenerate

  assign id_equal  = &bit_eq;
  assign addr_word = rx_valid && (wake_mode_e'(wake_sel) == WAKE_ON_ADDR) && rx_word[MSB];

  always_comb begin
    evt.is_addr = addr_word;
    evt.hit     = addr_word && id_equal;
    evt.miss    = addr_word && !id_equal;
  end
endmodule

// File: rtl/mw_mute_state.sv
module mw_mute_state
  import mute_wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mute_set,
  input  logic wake_sel,
  input  logic idle_det,
  input  logic addr_hit,
  input  logic addr_miss,
  output logic idle_wake,
  output logic muted
);
  logic muted_q;

  assign idle_wake = muted_q && idle_det && (wake_mode_e'(wake_sel) == WAKE_ON_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) muted_q <= 1'b0;
    else        muted_q <= mute_next(muted_q, mute_set, addr_hit, addr_miss, idle_wake);
  end

  assign muted = muted_q;
endmodule

// File: rtl/mw_rx_gate.sv
module mw_rx_gate #(
  parameter int DATA_W = 9,
  parameter int FLAG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass,
  input  logic [DATA_W-1:0] rx_word,
  input  logic [FLAG_W-1:0] rx_flags,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [FLAG_W-1:0] rx_flags_o
);
  logic [FLAG_W-1:0] flags_gated;

  generate
    for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
      assign flags_gated[f] = rx_flags[f] & pass;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      rx_flags_o <= '0;
    end else begin
      rx_valid_o <= pass;
      rx_flags_o <= flags_gated;
      if (pass) rx_data_o <= rx_word;
    end
  end
endmodule

// File: rtl/uart_mute_wakeup.sv
module uart_mute_wakeup
  import mute_wake_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ID_W   = 4,
  parameter int FLAG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_set,
  input  logic              wake_sel,
  input  logic [ID_W-1:0]   node_id,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_valid,
  input  logic [FLAG_W-1:0] rx_flags,
  input  logic              idle_det,
  output logic              muted,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [FLAG_W-1:0] rx_flags_o
);
  addr_evt_t evt;
  logic      addr_is;
  logic      addr_hit;
  logic      addr_miss;
  logic      idle_wake;
  logic      word_pass;

  mw_addr_detect #(.DATA_W(DATA_W), .ID_W(ID_W)) u_detect (
    .rx_valid (rx_valid),
    .rx_word  (rx_word),
    .wake_sel (wake_sel),
    .node_id  (node_id),
    .evt      (evt)
  );

  assign addr_is   = evt.is_addr;
  assign addr_hit  = evt.hit;
  assign addr_miss = evt.miss;

  mw_mute_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .mute_set  (mute_set),
    .wake_sel  (wake_sel),
    .idle_det  (idle_det),
    .addr_hit  (addr_hit),
    .addr_miss (addr_miss),
    .idle_wake (idle_wake),
    .muted     (muted)
  );

  assign word_pass = word_passes(rx_valid, addr_is, muted);

  mw_rx_gate #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .pass       (word_pass),
    .rx_word    (rx_word),
    .rx_flags   (rx_flags),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o),
    .rx_flags_o (rx_flags_o)
  );
endmodule

// File: rtl/mw_checker.sv
module mw_checker #(
  parameter int DATA_W = 9,
  parameter int ID_W   = 4,
  parameter int FLAG_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mute_set,
  input logic              wake_sel,
  input logic [ID_W-1:0]   node_id,
  input logic [DATA_W-1:0] rx_word,
  input logic              rx_valid,
  input logic              idle_det,
  input logic              muted,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic [FLAG_W-1:0] rx_flags_o,
  input logic              addr_hit,
  input logic              addr_miss,
  input logic              idle_wake
);
  logic is_addr_in;
  assign is_addr_in = rx_valid && wake_sel && rx_word[DATA_W-1];

  // R2
  mute_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_set |=> muted);

  // R3
  muted_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && rx_valid) |=> !rx_valid_o);

  // R4
  addr_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_addr_in |=> !rx_valid_o);

  // R5
  addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_addr_in && rx_word[ID_W-1:0] == node_id && !mute_set) |=> !muted);

  // R6
  addr_remute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_addr_in && rx_word[ID_W-1:0] != node_id) |=> muted);

  // R7
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && !wake_sel && idle_det && !mute_set) |=> !muted);

  // R8
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && !mute_set && !addr_hit && !idle_wake) |=> muted);

  // R8
  awake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!muted && !mute_set && !addr_miss) |=> !muted);

  // R9
  deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!muted && rx_valid && !is_addr_in) |=> (rx_valid_o && rx_data_o == $past(rx_word)));

  // R10
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> (rx_flags_o == '0));

  // R5
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({addr_hit, addr_miss, idle_wake}) <= 1);
endmodule

bind uart_mute_wakeup mw_checker #(.DATA_W(DATA_W), .ID_W(ID_W), .FLAG_W(FLAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mute_set   (mute_set),
  .wake_sel   (wake_sel),
  .node_id    (node_id),
  .rx_word    (rx_word),
  .rx_valid   (rx_valid),
  .idle_det   (idle_det),
  .muted      (muted),
  .rx_valid_o (rx_valid_o),
  .rx_data_o  (rx_data_o),
  .rx_flags_o (rx_flags_o),
  .addr_hit   (addr_hit),
  .addr_miss  (addr_miss),
  .idle_wake  (idle_wake)
);

// File: tb/uart_mute_wakeup_tb.sv
module uart_mute_wakeup_tb;
  localparam int DATA_W = 9;
  localparam int ID_W   = 4;
  localparam int FLAG_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mute_set = 1'b0;
  logic              wake_sel = 1'b0;
  logic [ID_W-1:0]   node_id = '0;
  logic [DATA_W-1:0] rx_word = '0;
  logic              rx_valid = 1'b0;
  logic [FLAG_W-1:0] rx_flags = '0;
  logic              idle_det = 1'b0;
  logic              muted;
  logic              rx_valid_o;
  logic [DATA_W-1:0] rx_data_o;
  logic [FLAG_W-1:0] rx_flags_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic m_muted = 1'b0;

  always #4 clk = ~clk;

  uart_mute_wakeup #(.DATA_W(DATA_W), .ID_W(ID_W), .FLAG_W(FLAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mute_set(mute_set), .wake_sel(wake_sel),
    .node_id(node_id), .rx_word(rx_word), .rx_valid(rx_valid), .rx_flags(rx_flags),
    .idle_det(idle_det), .muted(muted), .rx_valid_o(rx_valid_o),
    .rx_data_o(rx_data_o), .rx_flags_o(rx_flags_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input bit s, input bit v, input logic [DATA_W-1:0] w,
                      input logic [FLAG_W-1:0] fl, input bit idl);
    bit addr, match, deliver, nxt;
    string tag;
    mute_set = s; rx_valid = v; rx_word = w; rx_flags = fl; idle_det = idl;
    addr    = v && wake_sel && w[DATA_W-1];
    match   = (w[ID_W-1:0] == node_id);
    deliver = v && !addr && !m_muted;
    nxt = m_muted;
    if (s) nxt = 1'b1;
    else if (addr) nxt = !match;
    else if (!wake_sel && idl && m_muted) nxt = 1'b0;
    if (s) tag = "R2";
    else if (addr && match) tag = "R5";
    else if (addr) tag = "R6";
    else if (!wake_sel && idl && m_muted) tag = "R7";
    else if (idl) tag = "R8";
    else if (v && m_muted) tag = "R3";
    else tag = "R9";
    @(posedge clk);
    m_muted = nxt;
    @(negedge clk);
    chk(tag, int'(muted), int'(nxt));
    chk(addr ? "R4" : (deliver ? "R9" : "R3"), int'(rx_valid_o), int'(deliver));
    if (deliver) begin
      chk("R9", int'(rx_data_o), int'(w));
      chk("R9", int'(rx_flags_o), int'(fl));
    end else begin
      chk("R10", int'(rx_flags_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(muted), 0);
    chk("R1", int'(rx_valid_o), 0);
    chk("R1", int'(rx_flags_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(muted), 0);

    for (int sel = 0; sel < 2; sel++) begin
      for (int id = 0; id < 16; id++) begin
        wake_sel = sel[0];
        node_id  = id[ID_W-1:0];
        for (int pre = 0; pre < 2; pre++) begin
          for (int msb = 0; msb < 2; msb++) begin
            for (int up = 0; up < 2; up++) begin
              for (int lo = 0; lo < 16; lo++) begin
                for (int idl = 0; idl < 2; idl++) begin
                  logic [DATA_W-1:0] w;
                  logic [FLAG_W-1:0] fl;
                  w  = {msb[0], (up[0] ? 4'b1010 : 4'b0101), lo[3:0]};
                  fl = lo[1:0] ^ {up[0], idl[0]};
                  step(1'b1, 1'b0, '0, '0, 1'b0);
                  if (pre == 0) begin
                    if (sel == 1) step(1'b0, 1'b1, {1'b1, 4'b0000, id[3:0]}, '0, 1'b0);
                    else          step(1'b0, 1'b0, '0, '0, 1'b1);
                  end
                  step(1'b0, 1'b1, w, fl, idl[0]);
                end
              end
            end
          end
        end
      end
    end

    // R2: request coinciding with wakeup keeps the unit muted
    wake_sel = 1'b1; node_id = 4'h6;
    step(1'b1, 1'b0, '0, '0, 1'b0);
    step(1'b1, 1'b1, 9'h106, 2'b11, 1'b0);
    chk("R2", int'(muted), 1);
    wake_sel = 1'b0;
    step(1'b1, 1'b1, 9'h033, 2'b01, 1'b1);
    chk("R2", int'(muted), 1);
    // R8: idle line ignored in address mode while muted
    wake_sel = 1'b1;
    step(1'b0, 1'b0, '0, '0, 1'b1);
    chk("R8", int'(muted), 1);
    // R5: after matching address, following data words flow
    step(1'b0, 1'b1, 9'h106, 2'b00, 1'b0);
    step(1'b0, 1'b1, 9'h0A5, 2'b10, 1'b0);
    step(1'b0, 1'b1, 9'h05A, 2'b01, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule